// File: doc/BRIEF.md
# SPI Serial Clock Divider and Mode Strobe Generator

This block derives the serial clock of an SPI master from the system clock and tells a companion shift engine when to drive a new bit and when to capture an incoming one. A 5-bit divider code, a polarity bit, a phase bit and a capture-edge select come in as static configuration. A one-cycle request starts a burst of a given number of bit periods. While the burst runs the block drives the serial clock and two single-cycle strobes and holds a busy flag. When it is idle, the serial clock rests at the level the polarity bit selects.

The divider code has two ranges. The lower half gives the division ratio directly, for any ratio up to 15, odd or even. The upper half is offset by 16 and gives only even ratios, in steps of two, up to 30. The divider code and the mode bits are captured when a burst starts, so configuration writes made during a burst cannot bend a running bit period. For the fastest setting, a ratio of 1, the serial clock follows the system clock's high phase. The capture-edge select then picks which of the two edges in each cycle the sample strobe stands for.

Top module: `sck_divider`

## Requirements
- R1: After reset, busy is 0, launchStb and sampleStb are 0, and sck equals cpol.
- R2: Divider codes 0 to 15 give a bit period of max(code,1) system cycles: codes 0 and 1 both give 1, and code c from 2 to 15 gives c.
- R3: Divider codes 16 to 31 give a bit period of 2*(code-16) system cycles: code 17 gives 2 and code 31 gives 30. Code 16 gives 1.
- R4: startReq=1 with a non-zero bitCount while idle makes busy rise at the next clock edge. Busy then stays high for exactly bitCount times the bit period.
- R5: Whenever busy is 0, sck equals the live cpol input.
- R6: In each bit period of N cycles, sck sits at the inverse of the latched polarity for the first N-N/2 cycles and at the latched polarity for the rest. When N=1, sck is the inverse of the polarity while the system clock is high and the polarity itself while it is low. The leading edge falls in bit-cycle 0 and the trailing edge in bit-cycle N-N/2 (every cycle when N=1).
- R7: With cpha=0, sampleStb pulses in the leading-edge cycle and launchStb pulses in the trailing-edge cycle. With cpha=1 the two are swapped. With captureAlt=1 the launch placement is unchanged.
- R8: captureAlt=1 moves sampleStb to the other edge: it pulses on the trailing edge when cpha=0 and on the leading edge when cpha=1.
- R9: While busy, startReq is ignored. Changes to prescaleCode, cpha and captureAlt do not alter the running burst.
- R10: startReq with bitCount=0 starts nothing: busy stays 0 and sck stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| prescaleCode | input | PRE_W | Divider code, sampled when a burst starts |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: sample on the leading edge; 1: launch on the leading edge |
| captureAlt | input | 1 | Moves sampling to the opposite edge |
| startReq | input | 1 | One-cycle burst request |
| bitCount | input | CNT_W | Number of bit periods in the burst |
| sck | output | 1 | Serial clock |
| launchStb | output | 1 | Shift engine drives its next bit |
| sampleStb | output | 1 | Shift engine captures the input bit |
| busy | output | 1 | Burst in progress |

## Verification
The in-RTL assertions check on every cycle that the bit counter stays below the latched ratio, that the latched ratio holds steady through a burst, that busy drops right after the final cycle, that sck rests at cpol when idle, that strobes appear only during a burst, and that a zero-length request starts nothing. The bench scenarios are what show the arithmetic. They cover the exact period for all 32 codes, the position of the sck edges and the strobes inside a bit in all four modes with and without the alternate capture edge, the half-cycle sck at ratio 1, and the indifference of a running burst to mid-burst configuration changes.

// File: rtl/sck_divider_pkg.sv
package sck_divider_pkg;
  // Strobes and latched mode handed from the control to the datapath
  typedef struct packed {
    logic running;    // burst in progress
    logic leadEdge;   // cycle holding the leading sck edge
    logic trailEdge;  // cycle holding the trailing sck edge
    logic sckActive;  // sck away from idle level (ratio >= 2)
    logic unity;      // ratio of 1: sck follows the system clock
    logic polL;
    logic phaL;
    logic capL;
  } sckStrobes_t;
endpackage

// File: rtl/sck_divider_ctrl.sv
module sck_divider_ctrl
  import sck_divider_pkg::*;
#(
  parameter int PRE_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescaleCode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             captureAlt,
  input  logic             startReq,
  input  logic [CNT_W-1:0] bitCount,
  output sckStrobes_t      strb
);
  localparam int RATIO_W = PRE_W + 1;
  localparam logic [PRE_W-1:0] HALF_CODE = PRE_W'(1 << (PRE_W - 1));

  logic [RATIO_W-1:0] ratioNext, ratioL, halfL, cnt;
  logic [PRE_W-1:0]   evenStep;
  logic [CNT_W-1:0]   bitsLeft;
  logic               running, polL, phaL, capL;

  // Code decode: direct ratio in the lower half, even ratios above
  always_comb begin
    evenStep = prescaleCode - HALF_CODE;
    if (prescaleCode < HALF_CODE)
      ratioNext = (prescaleCode <= PRE_W'(1)) ? RATIO_W'(1) : {1'b0, prescaleCode};
    else
      ratioNext = (evenStep == '0) ? RATIO_W'(1) : {evenStep, 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      cnt      <= '0;
      bitsLeft <= '0;
      ratioL   <= RATIO_W'(1);
      polL     <= 1'b0;
      phaL     <= 1'b0;
      capL     <= 1'b0;
    end else if (!running) begin
      if (startReq && bitCount != '0) begin
        running  <= 1'b1;
        cnt      <= '0;
        bitsLeft <= bitCount;
        ratioL   <= ratioNext;
        polL     <= cpol;
        phaL     <= cpha;
        capL     <= captureAlt;
      end
    end else if (cnt == ratioL - RATIO_W'(1)) begin
      cnt      <= '0;
      bitsLeft <= bitsLeft - CNT_W'(1);
      if (bitsLeft == CNT_W'(1)) running <= 1'b0;
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  assign halfL = ratioL - (ratioL >> 1);

  always_comb begin
    strb.running   = running;
    strb.unity     = (ratioL == RATIO_W'(1));
    strb.leadEdge  = running && (cnt == '0);
    strb.trailEdge = running && (strb.unity || cnt == halfL);
    strb.sckActive = running && (cnt < halfL);
    strb.polL      = polL;
    strb.phaL      = phaL;
    strb.capL      = capL;
  end

  // R2 / R3: the in-period counter never reaches the latched ratio
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < ratioL));
  // R9: latched ratio holds for the whole burst
  p_ratio_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (!running || $stable(ratioL)));
  // R4: burst ends right after the last cycle of the last bit
  p_burst_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (running && bitsLeft == CNT_W'(1) && cnt == ratioL - RATIO_W'(1)) |=> !running);
  // R10: a zero-length request starts nothing
  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startReq && bitCount == '0) |=> !running);
endmodule

// File: rtl/sck_divider_dp.sv
module sck_divider_dp
  import sck_divider_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpol,
  input  sckStrobes_t strb,
  output logic        sck,
  output logic        launchStb,
  output logic        sampleStb
);
  logic activeLvl;

  // At ratio 1 the non-idle half is the system clock's high phase
  assign activeLvl = strb.unity ? clk : strb.sckActive;
  assign sck       = strb.running ? (strb.polL ^ activeLvl) : cpol;
  assign launchStb = strb.running && (strb.phaL ? strb.leadEdge : strb.trailEdge);
  assign sampleStb = strb.running &&
                     ((strb.phaL ^ strb.capL) ? strb.trailEdge : strb.leadEdge);

  // R5: idle sck follows the polarity input
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.running |-> (sck == cpol));
  // R7: no launch outside a burst
  p_launch_in_burst_r7: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |-> strb.running);
  // R8: no sample outside a burst
  p_sample_in_burst_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> strb.running);
endmodule

// File: rtl/sck_divider.sv
module sck_divider
  import sck_divider_pkg::*;
#(
  parameter int PRE_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescaleCode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             captureAlt,
  input  logic             startReq,
  input  logic [CNT_W-1:0] bitCount,
  output logic             sck,
  output logic             launchStb,
  output logic             sampleStb,
  output logic             busy
);
  sckStrobes_t strb;

  sck_divider_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .prescaleCode(prescaleCode), .cpol(cpol),
    .cpha(cpha), .captureAlt(captureAlt), .startReq(startReq),
    .bitCount(bitCount), .strb(strb)
  );

  sck_divider_dp u_dp (
    .clk(clk), .rstN(rstN), .cpol(cpol), .strb(strb),
    .sck(sck), .launchStb(launchStb), .sampleStb(sampleStb)
  );

  assign busy = strb.running;
endmodule

// File: tb/sim_sck_divider.sv
module sim_sck_divider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] prescaleCode = '0;
  logic       cpol = 1'b0, cpha = 1'b0, captureAlt = 1'b0;
  logic       startReq = 1'b0;
  logic [5:0] bitCount = '0;
  logic       sck, launchStb, sampleStb, busy;
  int         checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  sck_divider u0 (
    .clk(clk), .rstN(rstN), .prescaleCode(prescaleCode), .cpol(cpol),
    .cpha(cpha), .captureAlt(captureAlt), .startReq(startReq),
    .bitCount(bitCount), .sck(sck), .launchStb(launchStb),
    .sampleStb(sampleStb), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expRatio(input int code);
    if (code < 16) return (code < 2) ? 1 : code;
    return (code == 16) ? 1 : 2 * (code - 16);
  endfunction

  // Runs one burst and compares every cycle against the arithmetic model.
  task automatic runBurst(input string tag, input int code, input bit pol,
                          input bit pha, input bit cap, input int nb, input bit disturb);
    int n, half, c, mis[4], firstAct[4], firstExp[4];
    bit eBusy, eSck, eLead, eTrail, eLaunch, eSample;
    n = expRatio(code);
    half = n - n / 2;
    for (int i = 0; i < 4; i++) begin mis[i] = 0; firstAct[i] = 0; firstExp[i] = 0; end
    @(negedge clk);
    prescaleCode = 5'(code); cpol = pol; cpha = pha; captureAlt = cap;
    bitCount = 6'(nb); startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
    for (int t = 0; t <= nb * n; t++) begin
      if (disturb && t == 1) begin
        prescaleCode = 5'd3; cpha = ~pha; captureAlt = ~cap;
        bitCount = 6'd9; startReq = 1'b1;
      end
      if (disturb && t == 2) startReq = 1'b0;
      c = t % n;
      eBusy   = (t < nb * n);
      eLead   = eBusy && c == 0;
      eTrail  = eBusy && (n == 1 || c == half);
      eSck    = eBusy ? (pol ^ ((n == 1) ? 1'b1 : (c < half))) : pol;
      eLaunch = pha ? eLead : eTrail;
      eSample = (pha ^ cap) ? eTrail : eLead;
      if (busy != eBusy && mis[0]++ == 0) begin firstAct[0] = busy; firstExp[0] = eBusy; end
      if (sck != eSck && mis[1]++ == 0) begin firstAct[1] = sck; firstExp[1] = eSck; end
      if (launchStb != eLaunch && mis[2]++ == 0) begin firstAct[2] = launchStb; firstExp[2] = eLaunch; end
      if (sampleStb != eSample && mis[3]++ == 0) begin firstAct[3] = sampleStb; firstExp[3] = eSample; end
      if (n == 1 && eBusy) begin
        #2;  // system clock low phase
        if (sck != pol && mis[1]++ == 0) begin firstAct[1] = sck; firstExp[1] = pol; end
      end
      @(posedge clk); #1;
    end
    check({tag, " busy"},   mis[0] == 0, firstAct[0], firstExp[0]);
    check({tag, " sck"},    mis[1] == 0, firstAct[1], firstExp[1]);
    check({tag, " launch"}, mis[2] == 0, firstAct[2], firstExp[2]);
    check({tag, " sample"}, mis[3] == 0, firstAct[3], firstExp[3]);
    @(negedge clk);
    prescaleCode = 5'(code); cpha = pha; captureAlt = cap;
  endtask

  initial begin
    int codes[3];
    codes[0] = 1; codes[1] = 5; codes[2] = 20;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 busy", busy == 1'b0, busy, 0);
    check("R1 sck", sck == 1'b0, sck, 0);
    check("R1 strobes", {launchStb, sampleStb} == 2'b00, {launchStb, sampleStb}, 0);
    @(negedge clk); rstN = 1'b1;
    // R5: idle level follows live polarity
    cpol = 1'b1; #1;
    check("R5 idle high", sck == 1'b1, sck, 1);
    cpol = 1'b0; #1;
    check("R5 idle low", sck == 1'b0, sck, 0);
    // R2 / R3: every divider code
    for (int code = 0; code < 32; code++)
      runBurst(code < 16 ? "R2 ratio" : "R3 ratio", code, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    // R6 / R7 / R8: edge placement in all modes
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 8; m++)
        runBurst(m[2] ? "R8 capture alt" : "R7 mode", codes[k], m[1], m[0], m[2], 3, 1'b0);
    runBurst("R6 odd shape", 7, 1'b1, 1'b0, 1'b0, 2, 1'b0);
    runBurst("R4 long burst", 29, 1'b0, 1'b1, 1'b0, 5, 1'b0);
    // R9: mid-burst start and configuration changes have no effect
    runBurst("R9 disturb", 22, 1'b0, 1'b0, 1'b0, 3, 1'b1);
    runBurst("R9 disturb unity", 0, 1'b1, 1'b1, 1'b1, 4, 1'b1);
    // R10: zero-length request
    @(negedge clk);
    cpol = 1'b1; bitCount = 6'd0; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check("R10 zero busy", busy == 1'b0, busy, 0);
      check("R10 zero sck", sck == 1'b1, sck, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule